// File: doc/BRIEF.md
# Line Strip Divider

The line strip divider takes a raster stream of 12-bit pixels, one sensor line after another, and cuts each line by position into three adjacent vertical strips. With the default widths a line holds 5000 pixels. The left strip takes 1667 of them, the middle strip 1666 and the right strip 1667. Each strip goes to its own output channel. The split repeats identically on every line, so each downstream compressor sees an endless image of fixed width, no wider than the 4096 pixels a single compressor accepts.

Every input pixel has a valid qualifier. The first pixel of a line is marked with a start-of-line flag, and that flag restarts the position count. Each output channel is registered and carries its own valid, pixel data, start-of-line and end-of-line signals, so every strip has its own line framing. A sticky error output reports malformed lines:

- a line that is cut short by an early start-of-line;
- pixels that arrive while no line is open.

Strip widths are parameters. The line width is derived as their sum.

Top module: `strip_divider`

## Requirements
- R1: While reset is held and right after it is released, every bit of out_valid, out_sol and out_eol is 0, and err_len is 0.
- R2: Pixel index i of a line (index 0 is the pixel carrying in_sol) goes to channel 0 for i in 0..1666, to channel 1 for i in 1667..3332, and to channel 2 for i in 3333..4999. Channel c presents the pixel value unchanged on out_data[c*12 +: 12].
- R3: Each accepted pixel appears on its channel exactly one clock cycle after it is presented. At most one bit of out_valid is 1 in any cycle. Consecutive well-formed lines, sent back to back, are divided identically and do not raise err_len.
- R4: out_sol[c] is 1 together with out_valid[c] only for the first pixel of strip c, which is index 0, 1667 or 3333.
- R5: out_eol[c] is 1 together with out_valid[c] only for the last pixel of strip c, which is index 1666, 3332 or 4999.
- R6: A cycle with in_valid low produces no output one cycle later and does not advance the position. in_sol is ignored while in_valid is low.
- R7: A valid pixel carrying in_sol that arrives while a line is still open, before its 5000th pixel, sets err_len. That pixel starts a new line at index 0, and the new line is divided normally.
- R8: A valid pixel without in_sol that arrives while no line is open is not forwarded to any channel and sets err_len. No line is open after reset, and none is open after a line's 5000th pixel.
- R9: Once set, err_len stays 1 through any further traffic, including well-formed lines, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | Marks the first pixel of a line (only meaningful with in_valid) |
| in_data | input | 12 | Input pixel value |
| out_valid | output | 3 | Per-channel pixel valid, bit c for channel c |
| out_sol | output | 3 | Per-channel first pixel of the strip line |
| out_eol | output | 3 | Per-channel last pixel of the strip line |
| out_data | output | 36 | Per-channel pixel, channel c on bits c*12 +: 12 |
| err_len | output | 1 | Sticky line-length / framing error |

## Verification
Every result of the divider is due one rising edge after its stimulus. This covers the channel outputs for a pixel, the suppression of output in idle cycles and the setting of the error flag. The bench drives each input on a falling edge. It samples the outputs one nanosecond after the next rising edge, which is the first moment the registered response exists and well before the inputs change again. The error flag is read at that same point after the offending pixel, and then again after later traffic to show that it stays set.

// File: rtl/strip_div_pkg.sv
package strip_div_pkg;

    // Classification of one pixel position against one strip.
    typedef struct packed {
        logic hit;    // position lies inside this strip
        logic first;  // position is the strip's leftmost pixel
        logic last;   // position is the strip's rightmost pixel
    } strip_tag_t;

    // Largest strip a single downstream compressor accepts.
    localparam int MAX_STRIP_PIX = 4096;

endpackage

// File: rtl/line_tracker.sv
module line_tracker #(
    parameter int LINE_W = 5000,
    localparam int IDX_W = $clog2(LINE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             err
);

    localparam logic [IDX_W-1:0] CLOSED = IDX_W'(LINE_W);

    typedef struct packed {
        logic [IDX_W-1:0] pos;  // pixels taken in the current line; CLOSED = no line open
        logic             err;
    } trk_t;

    trk_t st_d, st_q;
    logic line_open;

    always_comb begin
        st_d      = st_q;
        line_open = (st_q.pos < CLOSED);
        idx       = in_sol ? '0 : st_q.pos;
        accept    = in_valid && (in_sol || line_open);
        if (in_valid) begin
            if (in_sol) begin
                st_d.pos = IDX_W'(1);
                if (line_open) begin
                    st_d.err = 1'b1;
                end
            end else if (line_open) begin
                st_d.pos = st_q.pos + IDX_W'(1);
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos <= CLOSED;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;

    // R7: an early start-of-line flags the error and restarts the count
    p_short_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && st_q.pos < CLOSED) |=> st_q.err);
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (st_q.pos == IDX_W'(1)));
    // R8: a stray pixel leaves the line closed and flags the error
    p_stray_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sol && st_q.pos == CLOSED) |=> (st_q.err && st_q.pos == CLOSED));
    // R9: the error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    // R6: idle cycles do not move the position
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.pos));

endmodule

// File: rtl/strip_locator.sv
module strip_locator
    import strip_div_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int STRIP_W [N_CH] = '{1667, 1666, 1667},
    parameter int IDX_W = 13
) (
    input  logic [IDX_W-1:0]            idx,
    output strip_tag_t [N_CH-1:0]       tags
);

    function automatic int strip_start(int c);
        int s;
        s = 0;
        for (int i = 0; i < c; i++) begin
            s += STRIP_W[i];
        end
        return s;
    endfunction

    for (genvar c = 0; c < N_CH; c++) begin : g_strip
        localparam int FIRST_IDX = strip_start(c);
        localparam int LAST_IDX  = strip_start(c) + STRIP_W[c] - 1;
        always_comb begin
            tags[c].hit   = (idx >= IDX_W'(FIRST_IDX)) && (idx <= IDX_W'(LAST_IDX));
            tags[c].first = (idx == IDX_W'(FIRST_IDX));
            tags[c].last  = (idx == IDX_W'(LAST_IDX));
        end
    end

endmodule

// File: rtl/chan_out_reg.sv
module chan_out_reg #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             first,
    input  logic             last,
    input  logic [PIX_W-1:0] din,
    output logic             valid,
    output logic             sol,
    output logic             eol,
    output logic [PIX_W-1:0] dout
);

    typedef struct packed {
        logic             v;
        logic             s;
        logic             e;
        logic [PIX_W-1:0] d;
    } ch_t;

    ch_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = fire;
        st_d.s = fire && first;
        st_d.e = fire && last;
        if (fire) begin
            st_d.d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.v;
    assign sol   = st_q.s;
    assign eol   = st_q.e;
    assign dout  = st_q.d;

    // R4, R5: framing marks only accompany a valid pixel
    p_marks_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s || st_q.e) |-> st_q.v);

endmodule

// File: rtl/strip_divider.sv
module strip_divider
    import strip_div_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int N_CH = 3,
    parameter int STRIP_W [N_CH] = '{1667, 1666, 1667}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sol,
    input  logic [PIX_W-1:0]        in_data,
    output logic [N_CH-1:0]         out_valid,
    output logic [N_CH-1:0]         out_sol,
    output logic [N_CH-1:0]         out_eol,
    output logic [N_CH*PIX_W-1:0]   out_data,
    output logic                    err_len
);

    function automatic int total_width();
        int s;
        s = 0;
        for (int i = 0; i < N_CH; i++) begin
            s += STRIP_W[i];
        end
        return s;
    endfunction

    localparam int LINE_W = total_width();
    localparam int IDX_W  = $clog2(LINE_W + 1);

    logic                  accept;
    logic [IDX_W-1:0]      idx;
    strip_tag_t [N_CH-1:0] tags;

    line_tracker #(.LINE_W(LINE_W)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .accept   (accept),
        .idx      (idx),
        .err      (err_len)
    );

    strip_locator #(.N_CH(N_CH), .STRIP_W(STRIP_W), .IDX_W(IDX_W)) u_locator (
        .idx  (idx),
        .tags (tags)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        chan_out_reg #(.PIX_W(PIX_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (accept && tags[c].hit),
            .first (tags[c].first),
            .last  (tags[c].last),
            .din   (in_data),
            .valid (out_valid[c]),
            .sol   (out_sol[c]),
            .eol   (out_eol[c]),
            .dout  (out_data[c*PIX_W +: PIX_W])
        );
    end

    // R3: the channels never fire together
    p_onehot_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));
    // R6: an idle input cycle yields no output on the next cycle
    p_idle_no_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_valid == '0));
    // R3: an accepted pixel shows up on exactly one channel next cycle
    p_accept_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ($countones(out_valid) == 1));

endmodule

// File: tb/strip_divider_tb.sv
module strip_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sol;
    logic [11:0] in_data;
    logic [2:0]  out_valid;
    logic [2:0]  out_sol;
    logic [2:0]  out_eol;
    logic [35:0] out_data;
    logic        err_len;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    strip_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_eol   (out_eol),
        .out_data  (out_data),
        .err_len   (err_len)
    );

    function automatic int ch_of(int i);
        if (i < 1667) return 0;
        if (i < 3333) return 1;
        return 2;
    endfunction

    function automatic bit is_first(int i);
        return (i == 0) || (i == 1667) || (i == 3333);
    endfunction

    function automatic bit is_last(int i);
        return (i == 1666) || (i == 3332) || (i == 4999);
    endfunction

    function automatic logic [11:0] pix(int i, int seed);
        return 12'((i * 37 + seed * 101) & 12'hFFF);
    endfunction

    // Drive one cycle, then check the registered response after the edge.
    task automatic step(input bit v, input bit s, input logic [11:0] d,
                        input int exp_ch, input bit ef, input bit el, input string req);
        logic [2:0]  ev;
        logic [2:0]  es;
        logic [2:0]  ee;
        bit          ok;
        @(negedge clk);
        in_valid = v;
        in_sol   = s;
        in_data  = d;
        @(posedge clk);
        #1;
        ev = (exp_ch < 0) ? 3'b000 : 3'(1 << exp_ch);
        es = ef ? ev : 3'b000;
        ee = el ? ev : 3'b000;
        ok = (out_valid == ev) && (out_sol == es) && (out_eol == ee);
        if (ok && exp_ch >= 0) ok = (out_data[exp_ch*12 +: 12] == d);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: valid=%b sol=%b eol=%b data=%h expected valid=%b sol=%b eol=%b data=%h",
                     req, out_valid, out_sol, out_eol, out_data, ev, es, ee, d);
        end
    endtask

    task automatic check_err(input bit exp, input string req);
        checks++;
        if (err_len !== exp) begin
            errors++;
            $display("FAIL %s: err_len=%b expected %b", req, err_len, exp);
        end
    endtask

    task automatic send_line(input int n, input int gap_every, input int seed, input string req);
        for (int i = 0; i < n; i++) begin
            if (gap_every > 0 && i % gap_every == 0) begin
                // idle cycle with start-of-line raised: must be ignored (R6)
                step(1'b0, 1'b1, 12'hABC, -1, 1'b0, 1'b0, "R6");
            end
            step(1'b1, i == 0, pix(i, seed), ch_of(i), is_first(i), is_last(i), req);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 3'b0 || out_sol !== 3'b0 || out_eol !== 3'b0 || err_len !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%b sol=%b eol=%b err=%b expected all zero",
                     out_valid, out_sol, out_eol, err_len);
        end
    endtask

    task automatic t_full_line();
        send_line(5000, 0, 1, "R2 R4 R5");
        check_err(1'b0, "R2");
    endtask

    task automatic t_gaps();
        send_line(5000, 5, 2, "R6 R2");
        check_err(1'b0, "R6");
    endtask

    task automatic t_back_to_back();
        send_line(5000, 0, 3, "R3");
        send_line(5000, 0, 4, "R3");
        check_err(1'b0, "R3");
    endtask

    task automatic t_short_line();
        do_reset();
        send_line(100, 0, 5, "R7");
        check_err(1'b0, "R7");
        send_line(5000, 0, 6, "R7");
        check_err(1'b1, "R7");
    endtask

    task automatic t_overrun();
        do_reset();
        send_line(5000, 0, 7, "R8");
        check_err(1'b0, "R8");
        step(1'b1, 1'b0, 12'h5A5, -1, 1'b0, 1'b0, "R8");
        check_err(1'b1, "R8");
        step(1'b0, 1'b0, 12'h000, -1, 1'b0, 1'b0, "R9");
        check_err(1'b1, "R9");
        send_line(5000, 0, 8, "R9");
        check_err(1'b1, "R9");
    endtask

    task automatic t_no_line();
        do_reset();
        step(1'b1, 1'b0, 12'h123, -1, 1'b0, 1'b0, "R8");
        check_err(1'b1, "R8");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_data  = '0;
        t_reset();
        t_full_line();
        t_gaps();
        t_back_to_back();
        t_short_line();
        t_overrun();
        t_no_line();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule